// File: doc/BRIEF.md
# RAM/ROM Chip-Select Address Decoder

This block is the memory subsystem of a small processor. The memory is built from four 128-byte RAM chips and one 512-byte ROM chip that share an 8-bit data bus. The processor presents an address, a read strobe and a write strobe. High address lines are decoded into a pair of select inputs for each chip. Each chip follows its own function table: it stays inhibited unless it is selected, it captures bus data on a write, and it drives the bus on a read.

Shared-bus contention is modelled with an explicit drive flag. When no chip drives, `bus_oe` is low and `cpu_rdata` reads zero, which stands for the high-impedance bus. Each chip has a small combinational function state. FN_INHIBIT is the rest state. The chip moves to FN_WRITE when it is selected and the write strobe is high; only RAM chips have this state. It moves to FN_READ when it is selected, the read strobe is high and the write strobe is low. It returns to FN_INHIBIT when the select is lost, when both strobes are low, or while reset is held.

Top module: `memsel_top`

## Requirements
- R1: Addresses 0x0000–0x007F, 0x0080–0x00FF, 0x0100–0x017F and 0x0180–0x01FF select RAM chips 0 to 3. Address bits [8:7] choose the chip and bits [6:0] give the offset inside it. Addresses 0x0200–0x03FF select the ROM, with bits [8:0] as the offset. `chip_en` bit k (k = 0..3) flags RAM chip k and bit 4 flags the ROM.
- R2: A chip acts only while its CS1 is 1 and its CS2 is 0. Otherwise its `chip_en` bit is 0, it does not drive the bus and it stores nothing.
- R3: A selected RAM chip with `cpu_wr`=1 stores `cpu_wdata` at the rising clock edge. This holds even when `cpu_rd` is also 1, and the chip does not drive the bus in that cycle.
- R4: A selected RAM chip with `cpu_rd`=1 and `cpu_wr`=0 drives its stored byte in the same cycle, with `bus_oe`=1.
- R5: A selected RAM chip with both strobes low is inhibited. `bus_oe` is 0 and `cpu_rdata` is 0.
- R6: A selected ROM with `cpu_rd`=1 and `cpu_wr`=0 drives the byte at offset o, which is o[7:0] XOR 0xA5 when o[8]=0 and o[7:0] XOR 0x5A when o[8]=1.
- R7: A write to ROM space drives nothing and changes no stored byte in any chip.
- R8: Addresses at or above 0x0400 select no chip. A read there leaves `bus_oe` at 0, and a write there changes no RAM byte.
- R9: At most one chip drives the bus in any cycle. When none drives, `bus_oe` is 0 and `cpu_rdata` is 0.
- R10: While `rst_n` is 0 no chip is selected, drives or stores, and RAM contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes land on its rising edge |
| rst_n | input | 1 | Active-low reset; inhibits every chip |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Byte the processor places on the bus for a write |
| cpu_rdata | output | 8 | Byte driven by the selected chip, 0 when the bus floats |
| bus_oe | output | 1 | High when some chip drives the bus |
| chip_en | output | 5 | Per-chip active select: bits 0–3 RAM chips, bit 4 ROM |

## Verification
The assertions assume that the strobes and the address stay stable from one rising edge to the next, because the write check compares memory one cycle later against the sampled address and data. They also assume that reset is released only on a clock boundary. The stimulus changes every input on the falling edge and holds it for a whole cycle. It asserts and releases reset through the same per-cycle driver task, so every write and every read spans exactly one rising edge.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    typedef enum logic [1:0] {
        FN_INHIBIT = 2'd0,
        FN_READ    = 2'd1,
        FN_WRITE   = 2'd2
    } chip_fn_e;

endpackage

// File: rtl/memsel_decoder.sv
module memsel_decoder #(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 7,
    parameter int SEL_W  = 2
) (
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    output logic [(1<<SEL_W)-1:0]   ram_cs1,
    output logic                    ram_cs2,
    output logic                    rom_cs1,
    output logic                    rom_cs2
);
    localparam int NRAM     = 1 << SEL_W;
    localparam int ROM_LINE = RAM_AW + SEL_W;

    logic in_window;
    logic [SEL_W-1:0] ram_pick;

    // Window covers everything below the first address past the ROM.
    assign in_window = rst_n && (addr[ADDR_W-1:ROM_LINE+1] == '0);
    assign ram_pick  = addr[RAM_AW +: SEL_W];

    // 2-to-N decoder feeding RAM CS1, enabled by the window.
    for (genvar k = 0; k < NRAM; k++) begin : g_dec
        assign ram_cs1[k] = in_window && (ram_pick == SEL_W'(k));
    end

    // ROM line high forbids every RAM chip and enables the ROM.
    assign ram_cs2 = addr[ROM_LINE];
    assign rom_cs1 = addr[ROM_LINE];
    assign rom_cs2 = ~in_window;

endmodule

// File: rtl/memsel_ram.sv
module memsel_ram
    import memsel_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs1,
    input  logic          cs2,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          doe
);
    localparam int DEPTH = 1 << AW;

    chip_fn_e fn;
    logic     sel;
    logic [DW-1:0] mem [DEPTH];

    assign sel = cs1 && !cs2;

    // Function state
    always_comb begin
        fn = FN_INHIBIT;
        unique casez ({sel, wr, rd})
            3'b0??:  fn = FN_INHIBIT;
            3'b11?:  fn = FN_WRITE;
            3'b101:  fn = FN_READ;
            3'b100:  fn = FN_INHIBIT;
            default: fn = FN_INHIBIT;
        endcase
    end

    // Storage
    always_ff @(posedge clk) begin
        if (fn == FN_WRITE) begin
            mem[addr] <= din;
        end
    end

    // Bus outputs
    always_comb begin
        doe  = 1'b0;
        dout = '0;
        unique case (fn)
            FN_READ: begin
                doe  = 1'b1;
                dout = mem[addr];
            end
            FN_WRITE, FN_INHIBIT: begin
                doe  = 1'b0;
                dout = '0;
            end
            default: ;
        endcase
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1 && !cs2 && wr) |=> (mem[$past(addr)] == $past(din)));

    a_r2_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs1 && !cs2) |-> !doe);

    a_r5_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |-> !doe);

endmodule

// File: rtl/memsel_rom.sv
module memsel_rom
    import memsel_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 8,
    parameter logic [DW-1:0] KEY_LO = 8'hA5,
    parameter logic [DW-1:0] KEY_HI = 8'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs1,
    input  logic          cs2,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          doe
);
    chip_fn_e fn;
    logic     sel;
    logic [DW-1:0] content;

    assign sel = cs1 && !cs2;

    // Contents are computed from the offset; no array is needed.
    assign content = addr[DW-1:0] ^ (addr[AW-1] ? KEY_HI : KEY_LO);

    // Function state: a ROM has no write state.
    always_comb begin
        fn = FN_INHIBIT;
        unique casez ({sel, wr, rd})
            3'b0??:  fn = FN_INHIBIT;
            3'b11?:  fn = FN_INHIBIT;
            3'b101:  fn = FN_READ;
            3'b100:  fn = FN_INHIBIT;
            default: fn = FN_INHIBIT;
        endcase
    end

    // Bus outputs
    always_comb begin
        doe  = 1'b0;
        dout = '0;
        unique case (fn)
            FN_READ: begin
                doe  = 1'b1;
                dout = content;
            end
            FN_WRITE, FN_INHIBIT: begin
                doe  = 1'b0;
                dout = '0;
            end
            default: ;
        endcase
    end

    a_r7_rom_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !doe);

endmodule

// File: rtl/memsel_top.sv
module memsel_top #(
    parameter int ADDR_W = 16,
    parameter int DW     = 8,
    parameter int RAM_AW = 7,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              bus_oe,
    output logic [(1<<SEL_W):0] chip_en
);
    localparam int NRAM   = 1 << SEL_W;
    localparam int NCHIP  = NRAM + 1;
    localparam int ROM_AW = RAM_AW + SEL_W;

    logic [NRAM-1:0]  ram_cs1;
    logic             ram_cs2;
    logic             rom_cs1;
    logic             rom_cs2;
    logic [NCHIP-1:0] drv;
    logic [DW-1:0]    chip_data [NCHIP];

    memsel_decoder #(
        .ADDR_W (ADDR_W),
        .RAM_AW (RAM_AW),
        .SEL_W  (SEL_W)
    ) u_dec (
        .rst_n   (rst_n),
        .addr    (cpu_addr),
        .ram_cs1 (ram_cs1),
        .ram_cs2 (ram_cs2),
        .rom_cs1 (rom_cs1),
        .rom_cs2 (rom_cs2)
    );

    for (genvar k = 0; k < NRAM; k++) begin : g_ram
        memsel_ram #(
            .AW (RAM_AW),
            .DW (DW)
        ) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .cs1   (ram_cs1[k]),
            .cs2   (ram_cs2),
            .rd    (cpu_rd),
            .wr    (cpu_wr),
            .addr  (cpu_addr[RAM_AW-1:0]),
            .din   (cpu_wdata),
            .dout  (chip_data[k]),
            .doe   (drv[k])
        );
        assign chip_en[k] = ram_cs1[k] && !ram_cs2;
    end

    memsel_rom #(
        .AW (ROM_AW),
        .DW (DW)
    ) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .cs1   (rom_cs1),
        .cs2   (rom_cs2),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .addr  (cpu_addr[ROM_AW-1:0]),
        .dout  (chip_data[NRAM]),
        .doe   (drv[NRAM])
    );
    assign chip_en[NRAM] = rom_cs1 && !rom_cs2;

    // Bus resolution: OR of gated drivers, zero when floating.
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NCHIP; i++) begin
            if (drv[i]) cpu_rdata = cpu_rdata | chip_data[i];
        end
    end
    assign bus_oe = |drv;

    a_r9_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv) <= 1);

    a_r1_one_chip_selected: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_en));

    a_r8_outside_window_float: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1:ROM_AW+1] != '0) |-> (!bus_oe && chip_en == '0));

    a_r10_reset_all_off: assert property (@(posedge clk)
        !rst_n |-> (chip_en == '0 && !bus_oe));

endmodule

// File: tb/sim_memsel_top.sv
module sim_memsel_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        bus_oe;
    logic [4:0]  chip_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] shadow [512];

    logic       q_oe   [$];
    logic [7:0] q_data [$];
    logic [4:0] q_en   [$];
    string      q_tag  [$];

    always #5 clk = ~clk;

    memsel_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .bus_oe    (bus_oe),
        .chip_en   (chip_en)
    );

    function automatic logic [7:0] rom_byte(input logic [8:0] off);
        return off[7:0] ^ (off[8] ? 8'h5A : 8'hA5);
    endfunction

    // Driver: one bus cycle, expected result pushed to the scoreboard.
    task automatic cyc(input logic rst, input logic [15:0] a, input logic rd,
                       input logic wr, input logic [7:0] d, input string tag);
        logic       e_oe;
        logic [7:0] e_data;
        logic [4:0] e_en;
        @(negedge clk);
        rst_n = rst; cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        e_oe = 1'b0; e_data = 8'h00; e_en = 5'b0;
        if (rst && a < 16'h0400) begin
            if (a < 16'h0200) begin
                e_en = 5'b1 << a[8:7];
                if (rd && !wr) begin e_oe = 1'b1; e_data = shadow[a[8:0]]; end
                if (wr) shadow[a[8:0]] = d;
            end else begin
                e_en = 5'b10000;
                if (rd && !wr) begin e_oe = 1'b1; e_data = rom_byte(a[8:0]); end
            end
        end
        q_oe.push_back(e_oe); q_data.push_back(e_data);
        q_en.push_back(e_en); q_tag.push_back(tag);
    endtask

    // Monitor: samples 2 ns after each rising edge, inputs held since the falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_oe.size() > 0) begin
                logic       e_oe;
                logic [7:0] e_data;
                logic [4:0] e_en;
                string      tag;
                e_oe = q_oe.pop_front(); e_data = q_data.pop_front();
                e_en = q_en.pop_front(); tag = q_tag.pop_front();
                n_tests++;
                if (bus_oe !== e_oe || cpu_rdata !== e_data || chip_en !== e_en) begin
                    n_fail++;
                    $display("FAIL %s addr=%h got oe=%b data=%h en=%b exp oe=%b data=%h en=%b",
                             tag, cpu_addr, bus_oe, cpu_rdata, chip_en, e_oe, e_data, e_en);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) shadow[i] = 8'h00;
        // R10: held in reset, a read selects nothing
        cyc(1'b0, 16'h0010, 1'b1, 1'b0, 8'h00, "R10 reset read");
        cyc(1'b0, 16'h0210, 1'b1, 1'b0, 8'h00, "R10 reset rom read");
        // R3: fill every RAM chip with a chip-specific pattern
        for (int a = 0; a < 512; a++) begin
            logic [15:0] aa;
            aa = 16'(a);
            cyc(1'b1, aa, 1'b0, 1'b1, (aa[7:0] + {aa[8:7], 6'h00}) ^ 8'h3C, "R3 write");
        end
        // R1 R4: read back all RAM
        for (int a = 0; a < 512; a++) begin
            cyc(1'b1, 16'(a), 1'b1, 1'b0, 8'h00, "R1 R4 ram read");
        end
        // R6: ROM reads, both halves and edges
        cyc(1'b1, 16'h0200, 1'b1, 1'b0, 8'h00, "R6 rom first");
        cyc(1'b1, 16'h02FF, 1'b1, 1'b0, 8'h00, "R6 rom low half end");
        cyc(1'b1, 16'h0300, 1'b1, 1'b0, 8'h00, "R6 rom high half");
        cyc(1'b1, 16'h03FF, 1'b1, 1'b0, 8'h00, "R6 rom last");
        for (int a = 16'h0200; a < 16'h0400; a += 7) begin
            cyc(1'b1, 16'(a), 1'b1, 1'b0, 8'h00, "R6 rom sweep");
        end
        // R5 R2: selected with strobes low
        cyc(1'b1, 16'h0085, 1'b0, 1'b0, 8'hFF, "R5 ram idle");
        cyc(1'b1, 16'h0285, 1'b0, 1'b0, 8'hFF, "R2 rom idle");
        // R7: write into ROM space, then look at ROM and aliased RAM
        cyc(1'b1, 16'h0200, 1'b0, 1'b1, 8'h77, "R7 rom write");
        cyc(1'b1, 16'h0200, 1'b1, 1'b0, 8'h00, "R7 rom after write");
        cyc(1'b1, 16'h0000, 1'b1, 1'b0, 8'h00, "R7 ram alias untouched");
        cyc(1'b1, 16'h0100, 1'b1, 1'b0, 8'h00, "R7 ram alias untouched");
        // R8: outside the window
        cyc(1'b1, 16'h0400, 1'b0, 1'b1, 8'hEE, "R8 write outside");
        cyc(1'b1, 16'h0400, 1'b1, 1'b0, 8'h00, "R8 read outside");
        cyc(1'b1, 16'hFFFF, 1'b1, 1'b0, 8'h00, "R8 read top");
        cyc(1'b1, 16'h0000, 1'b1, 1'b0, 8'h00, "R8 ram unchanged");
        // R3: both strobes high writes, no drive
        cyc(1'b1, 16'h0085, 1'b1, 1'b1, 8'h99, "R3 rd+wr write");
        cyc(1'b1, 16'h0085, 1'b1, 1'b0, 8'h00, "R3 rd+wr readback");
        // R10: mid-run reset ignores a write and keeps contents
        cyc(1'b1, 16'h0005, 1'b0, 1'b1, 8'h11, "R10 pre write");
        cyc(1'b0, 16'h0005, 1'b1, 1'b1, 8'hEE, "R10 write in reset");
        cyc(1'b0, 16'h0005, 1'b1, 1'b0, 8'h00, "R10 read in reset");
        cyc(1'b1, 16'h0005, 1'b1, 1'b0, 8'h00, "R10 kept after reset");
        // R9: idle bus floats
        cyc(1'b1, 16'h0005, 1'b0, 1'b0, 8'h00, "R9 idle float");
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        while (q_oe.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule